// File: doc/BRIEF.md
# Shared Line Buffer Partitioner

This block sits between one line buffer memory and two display clients, and divides the memory's entries between them. Client A always owns a window that starts at physical entry 0. Client B owns the window that starts at the first entry after client A's window and runs to the top of the memory. Each client issues accesses with a local address that counts from the start of its own window. The block adds the window base to form the physical address. An access whose local address is not inside the client's window is rejected: it never reaches the memory, and the block raises an out-of-range flag for that client.

The split comes from a split-control word. A 3-bit preset/manual selector picks one of four fixed fractions or a manual split. In manual mode a half-end field gives client A's window size divided by two. A written control word is only staged. It becomes active on the next frame-start strobe, so a window never moves in the middle of a frame.

Each client request port is a valid/ready stream. Client A is always ready. Client B's ready drops in any cycle where client A presents a request, and client B must then hold its request until ready returns. Read responses cannot be back-pressured. They appear as a one-cycle valid pulse exactly one cycle after the request is accepted, which matches the memory's single-cycle read latency.

Top module: `lb_share_part`

## Requirements
- R1: After reset the active split is preset 0 (each client owns half of the memory), both ready outputs are high, and the response valids and out-of-range flags are low.
- R2: When control bit 2 is 0, bits 1:0 select the split as client A's window size: 0 gives DEPTH/2, 1 gives 3*DEPTH/4, 2 gives DEPTH, and 3 gives DEPTH/4. Client B's window size is DEPTH minus client A's window size.
- R3: When control bit 2 is 1, client A's window size is twice the value F in the field at bits [4 +: ADDR_W], and bits 1:0 have no effect.
- R4: Client A's physical address equals its local address. Client B's physical address equals client A's window size plus its local address.
- R5: An access whose local address is greater than or equal to the client's window size leaves the memory port idle, so a rejected write changes nothing. That client's out-of-range flag is high in the cycle after the access is accepted.
- R6: A rejected read still produces a response valid pulse, and its data is zero.
- R7: When client A's window is the whole memory, every client B access is rejected.
- R8: A control write takes effect only on a frame-start strobe. A write made in the same cycle as the strobe takes effect at that strobe.
- R9: When both clients present requests in the same cycle, client A's request goes to the memory and client B's ready is low. Client B's held request is accepted in the first cycle without a client A request.
- R10: For an accepted read, the response valid and data appear exactly one cycle after acceptance. For an in-range read, the data is the memory's read data.
- R11: In manual mode a doubled end point above DEPTH is clamped to DEPTH, which leaves client B with no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the staged split-control word |
| cfg_wdata | input | ADDR_W+4 | Split-control word |
| frame_start | input | 1 | Strobe that makes the staged split active |
| a_valid | input | 1 | Client A request valid |
| a_ready | output | 1 | Client A request ready |
| a_we | input | 1 | Client A write (1) or read (0) |
| a_addr | input | ADDR_W | Client A local address |
| a_wdata | input | DATA_W | Client A write data |
| a_rvalid | output | 1 | Client A read response valid |
| a_rdata | output | DATA_W | Client A read response data |
| a_oor | output | 1 | Client A out-of-range flag for the previous accepted access |
| b_valid | input | 1 | Client B request valid |
| b_ready | output | 1 | Client B request ready |
| b_we | input | 1 | Client B write (1) or read (0) |
| b_addr | input | ADDR_W | Client B local address |
| b_wdata | input | DATA_W | Client B write data |
| b_rvalid | output | 1 | Client B read response valid |
| b_rdata | output | DATA_W | Client B read response data |
| b_oor | output | 1 | Client B out-of-range flag for the previous accepted access |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory physical address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read enable |

## Verification
Each split is tested with every local address of both clients. The splits are the four presets and a set of manual half-end values: zero, small values, the exact midpoint, the exact top of the memory, values past the top, and the all-ones field. Manual words carry nonzero preset bits to show that those bits are ignored. The sweep first writes data tied to the address through each client, then reads it back, and checks the memory port, the flag and the response on every access. This separates wrong window sizes, wrong bases and rejected accesses that leak into memory. Separate sequences drive both clients at once, and write control words with and without the frame strobe, to separate the priority rule from the staging rule.

// File: rtl/lb_part_pkg.sv
package lb_part_pkg;
  localparam int MODE_BIT  = 2;
  localparam int FIELD_LSB = 4;

  typedef enum logic [1:0] {
    SPLIT_HALF   = 2'd0,
    SPLIT_A3Q    = 2'd1,
    SPLIT_A_ALL  = 2'd2,
    SPLIT_A1Q    = 2'd3
  } split_preset_e;
endpackage

// File: rtl/lb_split_cfg.sv
module lb_split_cfg #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             frame_start,
  output logic [REG_W-1:0] active
);
  logic [REG_W-1:0] staged;
  logic [REG_W-1:0] staged_nxt;

  always_comb staged_nxt = cfg_we ? cfg_wdata : staged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= '0;
      active <= '0;
    end else begin
      staged <= staged_nxt;
      if (frame_start) active <= staged_nxt;
    end
  end

  AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active)); // R8
endmodule

// File: rtl/lb_split_decode.sv
module lb_split_decode
  import lb_part_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W+3:0] ctrl,
  output logic [ADDR_W:0]   a_size,
  output logic [ADDR_W:0]   b_size
);
  localparam int          SZ_W  = ADDR_W + 1;
  localparam logic [SZ_W-1:0] DEPTH = SZ_W'(1) << ADDR_W;

  logic [ADDR_W-1:0] half_end;
  logic [SZ_W-1:0]   twice_end;
  split_preset_e     preset;

  always_comb begin
    half_end  = ctrl[FIELD_LSB +: ADDR_W];
    twice_end = {half_end, 1'b0};
    preset    = split_preset_e'(ctrl[1:0]);
    if (ctrl[MODE_BIT]) begin
      a_size = (twice_end > DEPTH) ? DEPTH : twice_end;
    end else begin
      unique case (preset)
        SPLIT_HALF:  a_size = DEPTH >> 1;
        SPLIT_A3Q:   a_size = (DEPTH >> 1) + (DEPTH >> 2);
        SPLIT_A_ALL: a_size = DEPTH;
        SPLIT_A1Q:   a_size = DEPTH >> 2;
        default:     a_size = DEPTH >> 1;
      endcase
    end
    b_size = DEPTH - a_size;
  end
endmodule

// File: rtl/lb_client_map.sv
module lb_client_map #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W:0]   base,
  input  logic [ADDR_W:0]   size,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic [ADDR_W-1:0] phys
);
  always_comb begin
    in_range = ({1'b0, addr} < size);
    phys     = base[ADDR_W-1:0] + addr;
  end
endmodule

// File: rtl/lb_share_part.sv
module lb_share_part #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W+3:0] cfg_wdata,
  input  logic              frame_start,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic              a_rvalid,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_oor,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic              b_rvalid,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_oor,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int REG_W = ADDR_W + 4;
  localparam int SZ_W  = ADDR_W + 1;

  logic [REG_W-1:0]  ctrl;
  logic [SZ_W-1:0]   a_size, b_size;
  logic              a_in, b_in;
  logic [ADDR_W-1:0] a_phys, b_phys;
  logic              a_acc, b_acc, a_hit, b_hit;
  logic              a_rsp_q, b_rsp_q, a_hit_q, b_hit_q;

  lb_split_cfg #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .active(ctrl)
  );

  lb_split_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ctrl(ctrl), .a_size(a_size), .b_size(b_size)
  );

  lb_client_map #(.ADDR_W(ADDR_W)) u_map_a (
    .base('0), .size(a_size), .addr(a_addr), .in_range(a_in), .phys(a_phys)
  );

  lb_client_map #(.ADDR_W(ADDR_W)) u_map_b (
    .base(a_size), .size(b_size), .addr(b_addr), .in_range(b_in), .phys(b_phys)
  );

  always_comb begin
    a_ready   = 1'b1;
    b_ready   = !a_valid;
    a_acc     = a_valid;
    b_acc     = b_valid && !a_valid;
    a_hit     = a_acc && a_in;
    b_hit     = b_acc && b_in;
    mem_en    = a_hit || b_hit;
    mem_we    = a_hit ? a_we : (b_hit && b_we);
    mem_addr  = a_acc ? a_phys : b_phys;
    mem_wdata = a_acc ? a_wdata : b_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rsp_q <= 1'b0;
      b_rsp_q <= 1'b0;
      a_hit_q <= 1'b0;
      b_hit_q <= 1'b0;
      a_oor   <= 1'b0;
      b_oor   <= 1'b0;
    end else begin
      a_rsp_q <= a_acc && !a_we;
      b_rsp_q <= b_acc && !b_we;
      a_hit_q <= a_hit;
      b_hit_q <= b_hit;
      a_oor   <= a_acc && !a_in;
      b_oor   <= b_acc && !b_in;
    end
  end

  always_comb begin
    a_rvalid = a_rsp_q;
    b_rvalid = b_rsp_q;
    a_rdata  = (a_rsp_q && a_hit_q) ? mem_rdata : '0;
    b_rdata  = (b_rsp_q && b_hit_q) ? mem_rdata : '0;
  end

  AST_A_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_in) |-> !mem_en); // R5
  AST_A_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_in) |-> (mem_en && mem_addr == a_phys)); // R9
  AST_B_EMPTY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !a_valid && b_size == '0) |-> !mem_en); // R7
  AST_A_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rvalid && a_oor) |-> (a_rdata == '0)); // R6
  AST_B_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rvalid && b_oor) |-> (b_rdata == '0)); // R6
  AST_B_RSP_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && b_ready && !b_we |=> b_rvalid); // R10
endmodule

// File: tb/lb_share_part_test.sv
module lb_share_part_test;
  localparam int AW    = 5;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int RW    = AW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [RW-1:0] cfg_wdata = '0;
  logic frame_start = 1'b0;
  logic a_valid = 1'b0, a_we = 1'b0, b_valid = 1'b0, b_we = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic a_ready, a_rvalid, a_oor, b_ready, b_rvalid, b_oor;
  logic [DW-1:0] a_rdata, b_rdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] mem [DEPTH];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lb_share_part #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start),
    .a_valid(a_valid), .a_ready(a_ready), .a_we(a_we), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rvalid(a_rvalid), .a_rdata(a_rdata), .a_oor(a_oor),
    .b_valid(b_valid), .b_ready(b_ready), .b_we(b_we), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rvalid(b_rvalid), .b_rdata(b_rdata), .b_oor(b_oor),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int a_size_of(input logic [RW-1:0] c);
    int f;
    if (c[2]) begin
      f = 2 * int'(c[4 +: AW]);
      return (f > DEPTH) ? DEPTH : f;
    end
    case (c[1:0])
      2'd0: return DEPTH / 2;
      2'd1: return 3 * DEPTH / 4;
      2'd2: return DEPTH;
      default: return DEPTH / 4;
    endcase
  endfunction

  task automatic set_cfg(input logic [RW-1:0] v, input bit strobe);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v; frame_start = strobe;
    @(negedge clk);
    cfg_we = 1'b0; frame_start = 1'b0;
  endtask

  task automatic strobe_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // single access by one client; asz = expected client A window size
  task automatic access(input bit cb, input bit wr, input int addr,
                        input logic [DW-1:0] d, input int asz, input string req);
    int size, phys;
    bit inr;
    size = cb ? (DEPTH - asz) : asz;
    inr  = addr < size;
    phys = cb ? ((asz + addr) % DEPTH) : addr;
    @(negedge clk);
    if (cb) begin b_valid = 1'b1; b_we = wr; b_addr = AW'(addr); b_wdata = d; end
    else    begin a_valid = 1'b1; a_we = wr; a_addr = AW'(addr); a_wdata = d; end
    #1;
    chk({req, " R5 mem_en"}, int'(mem_en), int'(inr));
    if (inr) chk({req, " R4 phys"}, int'(mem_addr), phys);
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
    chk({req, " R5 oor"}, int'(cb ? b_oor : a_oor), int'(!inr));
    chk({req, " R10 rvalid"}, int'(cb ? b_rvalid : a_rvalid), int'(!wr));
    if (!wr) chk({req, " R6/R10 rdata"}, int'(cb ? b_rdata : a_rdata),
                 inr ? int'(d) : 0);
  endtask

  function automatic logic [DW-1:0] pat(input bit cb, input int a, input int k);
    return DW'((k * 97 + a * 5 + (cb ? 1000 : 3)) & 16'hffff);
  endfunction

  task automatic sweep(input logic [RW-1:0] v, input int k, input string req);
    int asz;
    asz = a_size_of(v);
    set_cfg(v, 1'b1);
    for (int a = 0; a < DEPTH; a++) access(1'b0, 1'b1, a, pat(1'b0, a, k), asz, req);
    for (int a = 0; a < DEPTH; a++) access(1'b1, 1'b1, a, pat(1'b1, a, k), asz, req);
    for (int a = 0; a < DEPTH; a++) access(1'b0, 1'b0, a, pat(1'b0, a, k), asz, req);
    for (int a = 0; a < DEPTH; a++) access(1'b1, 1'b0, a, pat(1'b1, a, k), asz, req);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 a_ready", int'(a_ready), 1);
    chk("R1 b_ready", int'(b_ready), 1);
    chk("R1 rvalid", int'(a_rvalid | b_rvalid), 0);
    chk("R1 oor", int'(a_oor | b_oor), 0);
    access(1'b0, 1'b1, DEPTH/2 - 1, 16'h1111, DEPTH/2, "R1 half");
    access(1'b0, 1'b1, DEPTH/2, 16'h2222, DEPTH/2, "R1 half");
    access(1'b1, 1'b1, 0, 16'h3333, DEPTH/2, "R1 half");

    // R2 presets, R7 whole buffer to client A
    for (int p = 0; p < 4; p++) sweep(RW'(p), p, p == 2 ? "R2 R7 preset" : "R2 preset");
    // R3 manual with junk preset bits; R11 clamp
    sweep(RW'({AW'(0), 4'b0111}), 10, "R3 manual");
    sweep(RW'({AW'(1), 4'b0101}), 11, "R3 manual");
    sweep(RW'({AW'(5), 4'b0110}), 12, "R3 manual");
    sweep(RW'({AW'(DEPTH/4), 4'b0100}), 13, "R3 manual");
    sweep(RW'({AW'(DEPTH/2), 4'b0111}), 14, "R11 manual top");
    sweep(RW'({AW'(DEPTH/2 + 3), 4'b0100}), 15, "R11 clamp");
    sweep(RW'({AW'(DEPTH - 1), 4'b0110}), 16, "R11 clamp");

    // R8 staging
    set_cfg(RW'(0), 1'b1);
    set_cfg(RW'(2), 1'b0);
    access(1'b1, 1'b1, 0, 16'h0abc, DEPTH/2, "R8 staged not yet");
    strobe_frame();
    access(1'b1, 1'b1, 0, 16'h0abd, DEPTH, "R8 after strobe");
    set_cfg(RW'(3), 1'b1);
    access(1'b0, 1'b1, DEPTH/4, 16'h0abe, DEPTH/4, "R8 same-cycle");

    // R9 priority: preset 0
    set_cfg(RW'(0), 1'b1);
    @(negedge clk);
    a_valid = 1'b1; a_we = 1'b1; a_addr = AW'(2); a_wdata = 16'h5a5a;
    b_valid = 1'b1; b_we = 1'b0; b_addr = AW'(3);
    #1;
    chk("R9 b_ready low", int'(b_ready), 0);
    chk("R9 a addr", int'(mem_addr), 2);
    chk("R9 a we", int'(mem_we), 1);
    @(negedge clk);
    a_valid = 1'b0;
    #1;
    chk("R9 b_ready back", int'(b_ready), 1);
    chk("R9 b addr", int'(mem_addr), DEPTH/2 + 3);
    chk("R9 b not early", int'(b_rvalid), 0);
    @(negedge clk);
    b_valid = 1'b0;
    chk("R9 R10 b rvalid", int'(b_rvalid), 1);
    chk("R9 R10 b rdata", int'(b_rdata), int'(mem[DEPTH/2 + 3]));
    access(1'b0, 1'b0, 2, 16'h5a5a, DEPTH/2, "R9 a write landed");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule